// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This unit decides where a 32-bit processor fetches next after the current instruction. It supports a mix of full-width and 16-bit compressed instructions. The inputs are the current program counter, two register operands, an immediate that has already been sign-extended, a decoded control-flow operation code, a compressed-length flag and a destination register index. The unit resolves the branch condition. It then produces the next program counter, a taken flag and the return address for jump-and-link forms. It also reports the register that should receive that return address and whether the write is allowed.

Decode, immediate extraction, the register file and alignment traps are outside this block. All of the work is combinational. The result then passes through an output register that a parameter can remove. With the default setting, the values presented in one cycle appear at the outputs after the next rising clock edge.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output is 0 after that edge. With the default registered outputs, a result appears after the first rising edge that samples its inputs and holds until the next edge.
- R2: The instruction step is 2 when `compressed_i` is 1, and 4 otherwise. Operation codes 9 to 12 always use a step of 2. Code 0 and codes 13 to 15 are not control transfers: `next_pc_o` is PC plus the step, `taken_o` is 0 and `link_we_o` is 0.
- R3: Code 1, a direct jump, gives `next_pc_o` = PC + imm and `taken_o` = 1. It gives `link_val_o` = PC + step, with `link_rd_o` = `rd_i`.
- R4: Code 2, a register jump with link, gives `next_pc_o` = (opa + imm) with bit 0 forced to 0. It gives `taken_o` = 1 and `link_val_o` = PC + step, with `link_rd_o` = `rd_i`.
- R5: Code 3 is taken when opa equals opb. Code 4 is taken when they differ.
- R6: Code 5 is taken when opa < opb as signed 32-bit values. Code 6 is taken when opa >= opb as signed values.
- R7: Code 7 is taken when opa < opb as unsigned values. Code 8 is taken when opa >= opb as unsigned values. For codes 3 to 8, a taken branch gives PC + imm and a branch that is not taken gives PC + step.
- R8: Code 9 is taken when opa is zero. Code 10 is taken when opa is nonzero. When taken, the result is PC + imm. When not taken, the result is PC + 2.
- R9: Code 11, a compressed register jump, gives `next_pc_o` = opa with bit 0 cleared. It ignores imm, sets `taken_o` = 1 and writes no link (`link_we_o` = 0).
- R10: Code 12, a compressed register jump with link, gives the same target as code 11. It sets `link_we_o` = 1, `link_rd_o` = 1 and `link_val_o` = PC + 2.
- R11: For codes 1 and 2, `link_we_o` is 1 only when `rd_i` is nonzero. `link_we_o` is never 1 while `link_rd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Current program counter |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 32 | Sign-extended immediate |
| op_i | input | 4 | Control-flow operation code |
| compressed_i | input | 1 | Current instruction is 16-bit |
| rd_i | input | 5 | Destination register index |
| next_pc_o | output | 32 | Next program counter |
| link_val_o | output | 32 | Return address |
| link_we_o | output | 1 | Return address write enable |
| link_rd_o | output | 5 | Return address register index |
| taken_o | output | 1 | Control transfer taken |

## Verification
The output register sits between the inputs and all five result ports. Every result is therefore due exactly one rising edge after its inputs are sampled. The bench changes the inputs on a falling edge and compares the outputs on the following falling edge, half a period after the register updates. Separately, the bench drives new inputs and samples again before the next rising edge. The outputs must still show the previous result at that point. The sweep covers every operation code, both instruction lengths, and operand pairs that are equal, signed-negative, unsigned-wrapping and zero.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN      = 32;
    localparam int RIDX_W    = 5;
    localparam int OP_W      = 4;
    localparam int STEP_FULL = 4;
    localparam int STEP_HALF = 2;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 4'd0,
        OP_JAL   = 4'd1,
        OP_JALR  = 4'd2,
        OP_BEQ   = 4'd3,
        OP_BNE   = 4'd4,
        OP_BLT   = 4'd5,
        OP_BGE   = 4'd6,
        OP_BLTU  = 4'd7,
        OP_BGEU  = 4'd8,
        OP_CBEQZ = 4'd9,
        OP_CBNEZ = 4'd10,
        OP_CJR   = 4'd11,
        OP_CJALR = 4'd12
    } flow_op_e;

    typedef enum logic [2:0] {
        CMP_EQ, CMP_NE, CMP_LT, CMP_GE, CMP_LTU, CMP_GEU, CMP_EQZ, CMP_NEZ
    } cmp_kind_e;

    typedef enum logic [1:0] {
        TGT_PC_REL, TGT_REG_IMM, TGT_REG_ONLY
    } tgt_sel_e;

    typedef struct packed {
        logic [XLEN-1:0]   next_pc;
        logic [XLEN-1:0]   link_val;
        logic              link_we;
        logic [RIDX_W-1:0] link_rd;
        logic              taken;
    } flow_res_t;

    function automatic flow_op_e to_op(input logic [OP_W-1:0] code);
        flow_op_e r;
        case (code)
            4'd1:    r = OP_JAL;
            4'd2:    r = OP_JALR;
            4'd3:    r = OP_BEQ;
            4'd4:    r = OP_BNE;
            4'd5:    r = OP_BLT;
            4'd6:    r = OP_BGE;
            4'd7:    r = OP_BLTU;
            4'd8:    r = OP_BGEU;
            4'd9:    r = OP_CBEQZ;
            4'd10:   r = OP_CBNEZ;
            4'd11:   r = OP_CJR;
            4'd12:   r = OP_CJALR;
            default: r = OP_NONE;
        endcase
        return r;
    endfunction

    function automatic logic forces_half(input flow_op_e op);
        return (op == OP_CBEQZ) || (op == OP_CBNEZ) ||
               (op == OP_CJR)   || (op == OP_CJALR);
    endfunction

    function automatic logic is_cond(input flow_op_e op);
        return (op >= OP_BEQ) && (op <= OP_CBNEZ);
    endfunction

    function automatic logic is_jump(input flow_op_e op);
        return (op == OP_JAL) || (op == OP_JALR) ||
               (op == OP_CJR) || (op == OP_CJALR);
    endfunction

    function automatic cmp_kind_e cmp_of(input flow_op_e op);
        cmp_kind_e k;
        case (op)
            OP_BNE:   k = CMP_NE;
            OP_BLT:   k = CMP_LT;
            OP_BGE:   k = CMP_GE;
            OP_BLTU:  k = CMP_LTU;
            OP_BGEU:  k = CMP_GEU;
            OP_CBEQZ: k = CMP_EQZ;
            OP_CBNEZ: k = CMP_NEZ;
            default:  k = CMP_EQ;
        endcase
        return k;
    endfunction

    function automatic tgt_sel_e tgt_of(input flow_op_e op);
        tgt_sel_e t;
        case (op)
            OP_JALR:          t = TGT_REG_IMM;
            OP_CJR, OP_CJALR: t = TGT_REG_ONLY;
            default:          t = TGT_PC_REL;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  cmp_kind_e    kind_i,
    output logic         hit_o
);
    logic eq, zero, slt, ult;

    assign eq   = (a_i == b_i);
    assign zero = (a_i == '0);
    assign ult  = (a_i < b_i);
    // signed order differs from unsigned only when the sign bits differ
    assign slt  = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : ult;

    always_comb begin
        case (kind_i)
            CMP_EQ:  hit_o = eq;
            CMP_NE:  hit_o = !eq;
            CMP_LT:  hit_o = slt;
            CMP_GE:  hit_o = !slt;
            CMP_LTU: hit_o = ult;
            CMP_GEU: hit_o = !ult;
            CMP_EQZ: hit_o = zero;
            CMP_NEZ: hit_o = !zero;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_addr.sv
module npc_addr
    import npc_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int SHORT = STEP_HALF,
    parameter int FULL  = STEP_FULL
) (
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] reg_i,
    input  logic [W-1:0] imm_i,
    input  tgt_sel_e     sel_i,
    input  logic         half_i,
    output logic [W-1:0] target_o,
    output logic [W-1:0] seq_o
);
    localparam logic [W-1:0] STEP_S = W'(SHORT);
    localparam logic [W-1:0] STEP_F = W'(FULL);

    logic [W-1:0] pc_rel, reg_rel, reg_sum;

    assign seq_o   = pc_i + (half_i ? STEP_S : STEP_F);
    assign pc_rel  = pc_i + imm_i;
    assign reg_sum = reg_i + imm_i;
    assign reg_rel = {reg_sum[W-1:1], 1'b0};

    always_comb begin
        case (sel_i)
            TGT_REG_IMM:  target_o = reg_rel;
            TGT_REG_ONLY: target_o = {reg_i[W-1:1], 1'b0};
            default:      target_o = pc_rel;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int REG_OUT  = 1,
    parameter int LINK_IDX = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   opa_i,
    input  logic [XLEN-1:0]   opb_i,
    input  logic [XLEN-1:0]   imm_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              compressed_i,
    input  logic [RIDX_W-1:0] rd_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic [XLEN-1:0]   link_val_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_rd_o,
    output logic              taken_o
);
    localparam logic [RIDX_W-1:0] LINK_R = RIDX_W'(LINK_IDX);

    flow_op_e     op;
    logic         half, hit, go;
    logic [XLEN-1:0] target, seq;
    flow_res_t    res_c, res_q;

    assign op   = to_op(op_i);
    assign half = compressed_i || forces_half(op);

    npc_cond #(.W(XLEN)) u_cond (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .kind_i(cmp_of(op)),
        .hit_o (hit)
    );

    npc_addr #(.W(XLEN), .SHORT(STEP_HALF), .FULL(STEP_FULL)) u_addr (
        .pc_i    (pc_i),
        .reg_i   (opa_i),
        .imm_i   (imm_i),
        .sel_i   (tgt_of(op)),
        .half_i  (half),
        .target_o(target),
        .seq_o   (seq)
    );

    assign go = is_jump(op) || (is_cond(op) && hit);

    always_comb begin
        res_c.next_pc  = go ? target : seq;
        res_c.taken    = go;
        res_c.link_val = seq;
        res_c.link_rd  = (op == OP_CJALR) ? LINK_R : rd_i;
        case (op)
            OP_JAL, OP_JALR: res_c.link_we = (rd_i != '0);
            OP_CJALR:        res_c.link_we = (LINK_R != '0);
            default:         res_c.link_we = 1'b0;
        endcase
    end

    generate
        if (REG_OUT != 0) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) res_q <= '0;
                else     res_q <= res_c;
            end
        end else begin : g_comb
            assign res_q = res_c;
        end
    endgenerate

    assign next_pc_o  = res_q.next_pc;
    assign link_val_o = res_q.link_val;
    assign link_we_o  = res_q.link_we;
    assign link_rd_o  = res_q.link_rd;
    assign taken_o    = res_q.taken;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
#(
    parameter int REG_OUT = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc_i,
    input logic [XLEN-1:0]   opa_i,
    input logic [OP_W-1:0]   op_i,
    input logic              compressed_i,
    input logic [XLEN-1:0]   next_pc_o,
    input logic [XLEN-1:0]   link_val_o,
    input logic              link_we_o,
    input logic [RIDX_W-1:0] link_rd_o,
    input logic              taken_o
);
    generate
        if (REG_OUT != 0) begin : g_chk
            // R1
            reset_clear_chk: assert property (@(posedge clk)
                rst |=> (next_pc_o == '0 && !taken_o && !link_we_o));

            // R2
            plain_step_chk: assert property (@(posedge clk) disable iff (rst)
                (op_i == 4'd0 || op_i >= 4'd13) |=>
                (!taken_o && !link_we_o &&
                 next_pc_o == $past(pc_i) + ($past(compressed_i) ? 32'd2 : 32'd4)));

            // R4
            jalr_even_chk: assert property (@(posedge clk) disable iff (rst)
                (op_i == 4'd2) |=> (taken_o && !next_pc_o[0]));

            // R9
            cjr_nolink_chk: assert property (@(posedge clk) disable iff (rst)
                (op_i == 4'd11) |=>
                (!link_we_o && taken_o && next_pc_o == {$past(opa_i[XLEN-1:1]), 1'b0}));

            // R10
            cjalr_link_chk: assert property (@(posedge clk) disable iff (rst)
                (op_i == 4'd12) |=>
                (link_we_o && link_rd_o == 5'd1 && link_val_o == $past(pc_i) + 32'd2));

            // R11
            no_x0_write_chk: assert property (@(posedge clk) disable iff (rst)
                link_we_o |-> (link_rd_o != '0));
        end
    endgenerate
endmodule

bind npc_unit npc_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pc_i        (pc_i),
    .opa_i       (opa_i),
    .op_i        (op_i),
    .compressed_i(compressed_i),
    .next_pc_o   (next_pc_o),
    .link_val_o  (link_val_o),
    .link_we_o   (link_we_o),
    .link_rd_o   (link_rd_o),
    .taken_o     (taken_o)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0, opa_i = '0, opb_i = '0, imm_i = '0;
    logic [3:0]  op_i = '0;
    logic        compressed_i = 1'b0;
    logic [4:0]  rd_i = '0;
    logic [31:0] next_pc_o, link_val_o;
    logic        link_we_o, taken_o;
    logic [4:0]  link_rd_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    npc_unit uut (
        .clk(clk), .rst(rst), .pc_i(pc_i), .opa_i(opa_i), .opb_i(opb_i),
        .imm_i(imm_i), .op_i(op_i), .compressed_i(compressed_i), .rd_i(rd_i),
        .next_pc_o(next_pc_o), .link_val_o(link_val_o), .link_we_o(link_we_o),
        .link_rd_o(link_rd_o), .taken_o(taken_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            1:       return "R3";
            2:       return "R4";
            3, 4:    return "R5";
            5, 6:    return "R6";
            7, 8:    return "R7";
            9, 10:   return "R8";
            11:      return "R9";
            12:      return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic run_vec(input int op, input bit comp, input logic [31:0] a,
                           input logic [31:0] b, input logic [31:0] imm,
                           input logic [4:0] rd, input logic [31:0] pc);
        logic [31:0] step, e_pc, e_link;
        bit e_tk, e_we, cond;
        logic [4:0] e_rd;
        string rq;
        @(negedge clk);
        op_i = 4'(op); compressed_i = comp; opa_i = a; opb_i = b;
        imm_i = imm; rd_i = rd; pc_i = pc;
        step   = (comp || (op >= 9 && op <= 12)) ? 32'd2 : 32'd4;
        e_link = pc + step;
        e_rd   = rd;
        e_we   = 0;
        cond   = 0;
        case (op)
            3:  cond = (a == b);
            4:  cond = (a != b);
            5:  cond = ($signed(a) < $signed(b));
            6:  cond = !($signed(a) < $signed(b));
            7:  cond = (a < b);
            8:  cond = !(a < b);
            9:  cond = (a == 0);
            10: cond = (a != 0);
            default: cond = 0;
        endcase
        if (op == 1) begin
            e_pc = pc + imm; e_tk = 1; e_we = (rd != 0);
        end else if (op == 2) begin
            e_pc = (a + imm) & 32'hFFFF_FFFE; e_tk = 1; e_we = (rd != 0);
        end else if (op >= 3 && op <= 10) begin
            e_tk = cond; e_pc = cond ? pc + imm : pc + step;
        end else if (op == 11) begin
            e_pc = a & 32'hFFFF_FFFE; e_tk = 1;
        end else if (op == 12) begin
            e_pc = a & 32'hFFFF_FFFE; e_tk = 1; e_we = 1; e_rd = 5'd1;
        end else begin
            e_pc = pc + step; e_tk = 0;
        end
        rq = req_of(op);
        @(negedge clk);
        chk(rq, "next_pc", next_pc_o, e_pc);
        chk(rq, "taken", {31'b0, taken_o}, {31'b0, e_tk});
        chk((op == 1 || op == 2) ? "R11" : rq, "link_we", {31'b0, link_we_o}, {31'b0, e_we});
        if (e_we) begin
            chk(rq, "link_val", link_val_o, e_link);
            chk("R11", "link_rd", {27'b0, link_rd_o}, {27'b0, e_rd});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] av, bv, imm;
        // R1: outputs held at zero under reset even with live inputs
        op_i = 4'd1; pc_i = 32'h100; imm_i = 32'h40; rd_i = 5'd3;
        repeat (3) @(negedge clk);
        chk("R1", "reset next_pc", next_pc_o, 32'h0);
        chk("R1", "reset taken", {31'b0, taken_o}, 32'h0);
        chk("R1", "reset link_we", {31'b0, link_we_o}, 32'h0);
        rst = 1'b0;

        for (int op = 0; op < 16; op++)
            for (int c = 0; c < 2; c++)
                for (int p = 0; p < 4; p++)
                    for (int r = 0; r < 2; r++) begin
                        case (p)
                            0: begin av = 32'h0000_1234; bv = 32'h0000_1234; end
                            1: begin av = 32'hFFFF_FFFB; bv = 32'h0000_0003; end
                            2: begin av = 32'hFFFF_FFFF; bv = 32'h0000_0001; end
                            default: begin av = 32'h0000_0000; bv = 32'h7FFF_FFFF; end
                        endcase
                        imm = (p % 2 == 1) ? 32'hFFFF_FFF8 : 32'h0000_0103;
                        run_vec(op, c[0], av, bv, imm, r[0] ? 5'd7 : 5'd0,
                                32'h0000_4000 + 32'(p * 16));
                    end

        // R1: result holds until the next rising edge
        run_vec(1, 1'b0, 32'h0, 32'h0, 32'h20, 5'd2, 32'h0000_8000);
        op_i = 4'd0; pc_i = 32'h0000_9000;
        #2;
        chk("R1", "hold before edge", next_pc_o, 32'h0000_8020);
        @(negedge clk);
        chk("R1", "update after edge", next_pc_o, 32'h0000_9004);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule